// File: doc/BRIEF.md
# Buffered Program Load Sequencer

This block sits behind the command decoder of a parallel NOR flash and runs the buffered-program command. It watches single-cycle bus writes. A setup code opens the sequence and fixes the target block. The next write gives a count n. Exactly n+1 data writes follow, and each one is captured with its address into a local buffer. The sequence then ends with a confirm code. Only after that code is accepted does the block hand the buffer to a program engine. The engine reads the buffer back through an index port and signals when it has finished.

The host first samples `buf_free` to learn whether the buffer can take a new load. Three things stop a sequence: a count above the limit for the current bus width, a write whose block bits leave the block fixed at setup, or a wrong code in the confirm slot. Any of these gives a one-cycle abort report and discards what was loaded. The first two also raise a sticky program-fail flag. Byte mode narrows both the count field and the stored data to 8 bits.

Top module: `wbuf_loader`

## Requirements
- R1: After a synchronous reset, `buf_free`=1, `abort_pulse`=0, `prog_fail`=0, `pe_start`=0, `done_pulse`=0 and `fill_count`=0.
- R2: While idle and not busy, a write whose low data byte is E8h opens a sequence at any address. It latches the address bits above the low BLK_BITS as the target block, clears `prog_fail` and sets `fill_count` to 0. Any other write while idle changes no output.
- R3: The write after setup carries n. In byte mode n is `wr_data[7:0]` and the upper byte is ignored. In word mode n is all 16 bits. The largest legal n is DEPTH-1 (31) in byte mode and DEPTH/2-1 (15) in word mode. A larger n aborts with `prog_fail`=1.
- R4: Exactly n+1 data writes are stored at indices 0..n with their full address. In byte mode only the low byte is stored, with the upper byte read back as 0. `fill_count` counts the stored entries.
- R5: A count or data write whose block bits differ from the block latched at setup aborts with `prog_fail`=1.
- R6: The write after the last data write must have low byte D0h. Any other value aborts the sequence and leaves `prog_fail` at 0.
- R7: An accepted confirm raises `pe_start` for one cycle, with `pe_len`=n and `pe_block` set to the setup block. `buf_free` is then 0 until `pe_done`, and `done_pulse` is high for the one cycle after `pe_done`.
- R8: An E8h write while the buffer is busy is ignored. `buf_free` stays 0, no abort is reported and `fill_count` is unchanged.
- R9: An abort shows as `abort_pulse` for exactly one cycle, with `fill_count` already 0. The block is then idle with `buf_free`=1. `prog_fail` holds until the next accepted E8h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| byte_mode | input | 1 | 1 = 8-bit bus, 0 = 16-bit bus |
| wr_en | input | 1 | One-cycle bus write strobe |
| wr_addr | input | AW (12) | Write address; top AW-BLK_BITS bits select the block |
| wr_data | input | 16 | Write data |
| pe_done | input | 1 | Program engine finished |
| rd_idx | input | IW (5) | Buffer read index for the engine |
| buf_free | output | 1 | Buffer can accept a new sequence |
| abort_pulse | output | 1 | One-cycle abort report |
| prog_fail | output | 1 | Sticky fail status for a range or block error |
| fill_count | output | IW+1 (6) | Entries captured in the current load |
| pe_start | output | 1 | One-cycle start request to the engine |
| pe_len | output | IW (5) | Count n of the confirmed load |
| pe_block | output | AW-BLK_BITS (6) | Block of the confirmed load |
| rd_addr | output | AW (12) | Stored address at `rd_idx` |
| rd_data | output | 16 | Stored data at `rd_idx` |
| done_pulse | output | 1 | One-cycle completion report |

## Verification
Every control result is registered once. Each write is sampled on one rising edge, and `abort_pulse`, `prog_fail`, `fill_count`, `pe_start`, `pe_len` and `buf_free` take their new values right after that edge. `done_pulse` likewise follows the edge that samples `pe_done`. The bench drives each stimulus for one cycle from the falling edge and checks on the next falling edge, half a cycle after the result is due. It checks again one cycle later to confirm that the pulses have dropped. Buffer contents come out through a combinational read port, so they are checked a short delay after `rd_idx` is set. The bench sweeps every legal count in both modes and adds each abort case.

// File: rtl/wbuf_pkg.sv
// Shared codes and state type for the buffered-program load sequencer.
// Assumes commands arrive on the low data byte in both bus modes.
package wbuf_pkg;
    localparam int          DW          = 16;
    localparam logic [7:0]  CMD_SETUP   = 8'hE8;
    localparam logic [7:0]  CMD_CONFIRM = 8'hD0;

    typedef enum logic [2:0] {
        S_IDLE, S_COUNT, S_LOAD, S_CONFIRM, S_BUSY, S_ABORT
    } seq_state_t;
endpackage

// File: rtl/wbuf_store.sv
// Buffer storage: DEPTH address/data entries, written one at a time and
// read combinationally for the program engine.
// Assumes DEPTH is a power of two so every rd_idx value addresses an entry.
module wbuf_store #(
    parameter int DEPTH = 32,
    parameter int AW    = 12,
    parameter int IW    = $clog2(DEPTH)
) (
    input  logic                   clk,
    input  logic                   we,
    input  logic [IW-1:0]          wr_idx,
    input  logic [AW-1:0]          wr_a,
    input  logic [wbuf_pkg::DW-1:0] wr_d,
    input  logic [IW-1:0]          rd_idx,
    output logic [AW-1:0]          rd_a,
    output logic [wbuf_pkg::DW-1:0] rd_d
);
    logic [AW-1:0]           addr_q [DEPTH];
    logic [wbuf_pkg::DW-1:0] data_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        // Capture one entry when its index is selected.
        always_ff @(posedge clk) begin
            if (we && wr_idx == IW'(g)) begin
                addr_q[g] <= wr_a;
                data_q[g] <= wr_d;
            end
        end
    end

    assign rd_a = addr_q[rd_idx];
    assign rd_d = data_q[rd_idx];
endmodule

// File: rtl/wbuf_ctrl.sv
// Sequencer FSM: setup, count, data capture, confirm, busy and abort.
// Assumes wr_en is a single-cycle strobe and byte_mode is stable during
// a sequence.
module wbuf_ctrl
    import wbuf_pkg::*;
#(
    parameter int DEPTH    = 32,
    parameter int AW       = 12,
    parameter int BLK_BITS = 6,
    parameter int IW       = $clog2(DEPTH)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                byte_mode,
    input  logic                wr_en,
    input  logic [AW-1:0]       wr_addr,
    input  logic [DW-1:0]       wr_data,
    input  logic                pe_done,
    output logic                st_we,
    output logic [IW-1:0]       st_idx,
    output logic [DW-1:0]       st_data,
    output logic                buf_free,
    output logic                abort_pulse,
    output logic                prog_fail,
    output logic [IW:0]         fill_count,
    output logic                pe_start,
    output logic [IW-1:0]       pe_len,
    output logic [AW-BLK_BITS-1:0] pe_block,
    output logic                done_pulse
);
    localparam int BW = AW - BLK_BITS;
    localparam logic [DW-1:0] BYTE_MAX = DW'(DEPTH - 1);
    localparam logic [DW-1:0] WORD_MAX = DW'(DEPTH / 2 - 1);

    seq_state_t    state;
    logic [BW-1:0] blk_q;
    logic [IW-1:0] cnt_q;
    logic [IW:0]   fill_q;
    logic          fail_q, start_q, done_q;

    logic [BW-1:0] wr_blk;
    logic          in_blk;
    logic [DW-1:0] n_val;
    logic          n_bad;
    logic [7:0]    code;

    // Decode the incoming write: block bits, count value and range.
    always_comb begin
        wr_blk = wr_addr[AW-1:BLK_BITS];
        in_blk = (wr_blk == blk_q);
        n_val  = byte_mode ? {8'h00, wr_data[7:0]} : wr_data;
        n_bad  = n_val > (byte_mode ? BYTE_MAX : WORD_MAX);
        code   = wr_data[7:0];
    end

    // Sequence state, latched setup fields and registered status pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            blk_q   <= '0;
            cnt_q   <= '0;
            fill_q  <= '0;
            fail_q  <= 1'b0;
            start_q <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            start_q <= 1'b0;
            done_q  <= 1'b0;
            unique case (state)
                S_IDLE: if (wr_en && code == CMD_SETUP) begin
                    state  <= S_COUNT;
                    blk_q  <= wr_blk;
                    fail_q <= 1'b0;
                    fill_q <= '0;
                end
                S_COUNT: if (wr_en) begin
                    if (!in_blk || n_bad) begin
                        state  <= S_ABORT;
                        fail_q <= 1'b1;
                    end else begin
                        cnt_q <= n_val[IW-1:0];
                        state <= S_LOAD;
                    end
                end
                S_LOAD: if (wr_en) begin
                    if (!in_blk) begin
                        state  <= S_ABORT;
                        fail_q <= 1'b1;
                        fill_q <= '0;
                    end else begin
                        fill_q <= fill_q + 1'b1;
                        if (fill_q[IW-1:0] == cnt_q) state <= S_CONFIRM;
                    end
                end
                S_CONFIRM: if (wr_en) begin
                    if (code == CMD_CONFIRM) begin
                        state   <= S_BUSY;
                        start_q <= 1'b1;
                    end else begin
                        state  <= S_ABORT;
                        fill_q <= '0;
                    end
                end
                S_BUSY: if (pe_done) begin
                    state  <= S_IDLE;
                    done_q <= 1'b1;
                end
                S_ABORT: state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    // Store port and registered outputs.
    always_comb begin
        st_we       = (state == S_LOAD) && wr_en && in_blk;
        st_idx      = fill_q[IW-1:0];
        st_data     = byte_mode ? {8'h00, wr_data[7:0]} : wr_data;
        buf_free    = (state != S_BUSY);
        abort_pulse = (state == S_ABORT);
        prog_fail   = fail_q;
        fill_count  = fill_q;
        pe_start    = start_q;
        pe_len      = cnt_q;
        pe_block    = blk_q;
        done_pulse  = done_q;
    end
endmodule

// File: rtl/wbuf_loader.sv
// Top of the buffered-program load sequencer: control FSM plus buffer store.
// Assumes the program engine reads entries 0..pe_len through rd_idx
// while buf_free is low.
module wbuf_loader #(
    parameter int DEPTH    = 32,
    parameter int AW       = 12,
    parameter int BLK_BITS = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    byte_mode,
    input  logic                    wr_en,
    input  logic [AW-1:0]           wr_addr,
    input  logic [15:0]             wr_data,
    input  logic                    pe_done,
    input  logic [$clog2(DEPTH)-1:0] rd_idx,
    output logic                    buf_free,
    output logic                    abort_pulse,
    output logic                    prog_fail,
    output logic [$clog2(DEPTH):0]  fill_count,
    output logic                    pe_start,
    output logic [$clog2(DEPTH)-1:0] pe_len,
    output logic [AW-BLK_BITS-1:0]  pe_block,
    output logic [AW-1:0]           rd_addr,
    output logic [15:0]             rd_data,
    output logic                    done_pulse
);
    localparam int IW = $clog2(DEPTH);

    logic          st_we;
    logic [IW-1:0] st_idx;
    logic [15:0]   st_data;

    wbuf_ctrl #(.DEPTH(DEPTH), .AW(AW), .BLK_BITS(BLK_BITS), .IW(IW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .byte_mode(byte_mode), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .pe_done(pe_done),
        .st_we(st_we), .st_idx(st_idx), .st_data(st_data),
        .buf_free(buf_free), .abort_pulse(abort_pulse), .prog_fail(prog_fail),
        .fill_count(fill_count), .pe_start(pe_start), .pe_len(pe_len),
        .pe_block(pe_block), .done_pulse(done_pulse)
    );

    wbuf_store #(.DEPTH(DEPTH), .AW(AW), .IW(IW)) u_store (
        .clk(clk), .we(st_we), .wr_idx(st_idx), .wr_a(wr_addr), .wr_d(st_data),
        .rd_idx(rd_idx), .rd_a(rd_addr), .rd_d(rd_data)
    );
endmodule

// File: rtl/wbuf_loader_chk.sv
// Protocol checker for wbuf_loader, attached by bind below.
// Assumes the same synchronous active-low reset as the design.
module wbuf_loader_chk #(
    parameter int DEPTH = 32,
    parameter int IW    = 5
) (
    input logic        clk,
    input logic        rst_n,
    input logic        pe_done,
    input logic        buf_free,
    input logic        abort_pulse,
    input logic [IW:0] fill_count,
    input logic        pe_start,
    input logic        done_pulse
);
    a_r9_abort_single: assert property (@(posedge clk) disable iff (!rst_n)
        abort_pulse |=> !abort_pulse);
    a_r9_abort_flushes: assert property (@(posedge clk) disable iff (!rst_n)
        abort_pulse |-> (fill_count == '0) && buf_free);
    a_r7_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        pe_start |-> !buf_free);
    a_r7_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (!buf_free && !pe_done) |=> !buf_free);
    a_r7_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |-> $past(pe_done) && $past(!buf_free));
    a_r8_busy_no_abort: assert property (@(posedge clk) disable iff (!rst_n)
        !buf_free |-> !abort_pulse);
    a_r4_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
        fill_count <= (IW+1)'(DEPTH));
endmodule

bind wbuf_loader wbuf_loader_chk #(.DEPTH(DEPTH), .IW(IW)) u_chk (
    .clk(clk), .rst_n(rst_n), .pe_done(pe_done), .buf_free(buf_free),
    .abort_pulse(abort_pulse), .fill_count(fill_count),
    .pe_start(pe_start), .done_pulse(done_pulse)
);

// File: tb/sim_wbuf_loader.sv
module sim_wbuf_loader;
    localparam int DEPTH = 32, AW = 12, BLK = 6, IW = 5, LAT = 3;

    logic clk = 1'b0, rst_n = 1'b0, byte_mode = 1'b0, wr_en = 1'b0, pe_done = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [15:0]   wr_data = '0;
    logic [IW-1:0] rd_idx = '0;
    logic buf_free, abort_pulse, prog_fail, pe_start, done_pulse;
    logic [IW:0]   fill_count;
    logic [IW-1:0] pe_len;
    logic [AW-BLK-1:0] pe_block;
    logic [AW-1:0] rd_addr;
    logic [15:0]   rd_data;

    int total = 0, bad = 0, cyc = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    wbuf_loader #(.DEPTH(DEPTH), .AW(AW), .BLK_BITS(BLK)) u0 (
        .clk(clk), .rst_n(rst_n), .byte_mode(byte_mode), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .pe_done(pe_done), .rd_idx(rd_idx),
        .buf_free(buf_free), .abort_pulse(abort_pulse), .prog_fail(prog_fail),
        .fill_count(fill_count), .pe_start(pe_start), .pe_len(pe_len),
        .pe_block(pe_block), .rd_addr(rd_addr), .rd_data(rd_data),
        .done_pulse(done_pulse)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic ck(input string req, input int act, input int exp);
        chk(act == exp, req, act, exp);
    endtask

    task automatic wr(input int blk, input int off, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = {6'(blk), 6'(off)}; wr_data = 16'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic int pat(input int n, input int i);
        return (n * 257 + i * 4099 + 16'h1234) & 16'hFFFF;
    endfunction

    task automatic after_abort(input string req, input int fail_exp);
        ck({req, " abort high"}, abort_pulse, 1);
        ck({req, " fill flushed"}, fill_count, 0);
        ck({req, " fail flag"}, prog_fail, fail_exp);
        @(negedge clk);
        ck({req, " abort one cycle"}, abort_pulse, 0);
        ck({req, " idle free"}, buf_free, 1);
    endtask

    // Full legal sequence with count n in the current mode.
    task automatic run_seq(input int n, input int blk);
        int mask;
        mask = byte_mode ? 16'h00FF : 16'hFFFF;
        wr(blk, 5, 16'h33E8);
        ck("R2 setup fill", fill_count, 0);
        ck("R2 setup no abort", abort_pulse, 0);
        wr(blk, 9, byte_mode ? (16'h7700 | n) : n);
        ck("R3 legal count no abort", abort_pulse, 0);
        for (int i = 0; i <= n; i++) wr(blk, (i * 3) & 63, pat(n, i));
        ck("R4 fill after load", fill_count, n + 1);
        wr(blk, 1, 16'h55D0);
        ck("R7 start", pe_start, 1);
        ck("R7 busy", buf_free, 0);
        ck("R7 len", pe_len, n);
        ck("R7 block", pe_block, blk);
        @(negedge clk);
        ck("R7 start one cycle", pe_start, 0);
        wr((blk + 1) & 63, 0, 16'h00E8);
        ck("R8 busy stays", buf_free, 0);
        ck("R8 no abort", abort_pulse, 0);
        ck("R8 fill kept", fill_count, n + 1);
        for (int i = 0; i <= n; i++) begin
            rd_idx = 5'(i);
            #1;
            ck("R4 stored data", rd_data, pat(n, i) & mask);
            ck("R4 stored addr", rd_addr, (blk << 6) | ((i * 3) & 63));
        end
        repeat (LAT) @(negedge clk);
        ck("R7 busy until done", buf_free, 0);
        pe_done = 1'b1;
        @(negedge clk);
        pe_done = 1'b0;
        ck("R7 done pulse", done_pulse, 1);
        ck("R7 free after done", buf_free, 1);
        @(negedge clk);
        ck("R7 done one cycle", done_pulse, 0);
    endtask

    task automatic report;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            finished = 1;
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
            report();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        ck("R1 free", buf_free, 1);
        ck("R1 abort", abort_pulse, 0);
        ck("R1 fail", prog_fail, 0);
        ck("R1 fill", fill_count, 0);
        ck("R1 start", pe_start, 0);
        ck("R1 done", done_pulse, 0);

        // R3 R4 R7 R8: every legal count in both modes
        for (int m = 0; m < 2; m++) begin
            byte_mode = m[0];
            for (int n = 0; n <= (m ? 31 : 15); n++) run_seq(n, (n * 7 + m) & 63);
        end

        // R2: idle writes other than setup change nothing
        wr(4, 0, 16'h00D0);
        ck("R2 idle ignore start", pe_start, 0);
        ck("R2 idle ignore abort", abort_pulse, 0);
        ck("R2 idle ignore fill", fill_count, 32);

        // R3: counts above the limit
        byte_mode = 1'b1;
        wr(2, 0, 16'h00E8); wr(2, 0, 16'h0020); after_abort("R3 byte n=32", 1);
        byte_mode = 1'b0;
        wr(2, 0, 16'h00E8); wr(2, 0, 16'h0010); after_abort("R3 word n=16", 1);
        wr(2, 0, 16'h00E8); wr(2, 0, 16'h0100); after_abort("R3 word n=100h", 1);

        // R9: fail flag sticky across idle writes, cleared by setup
        wr(2, 0, 16'h0070);
        ck("R9 fail sticky", prog_fail, 1);
        wr(2, 0, 16'h00E8);
        ck("R9 fail cleared by setup", prog_fail, 0);
        wr(2, 0, 16'h0001); wr(2, 1, 16'h1111); wr(2, 2, 16'h2222); wr(2, 3, 16'h00D0);
        pe_done = 1'b1; @(negedge clk); pe_done = 1'b0; @(negedge clk);

        // R5: block mismatch on the count and on a data write
        wr(3, 0, 16'h00E8); wr(4, 0, 16'h0002); after_abort("R5 count block", 1);
        wr(7, 0, 16'h00E8); wr(7, 0, 16'h0003); wr(7, 1, 16'hAAAA);
        ck("R4 partial fill", fill_count, 1);
        wr(8, 2, 16'hBBBB); after_abort("R5 data block", 1);

        // R6: wrong confirm code
        wr(9, 0, 16'h00E8); wr(9, 0, 16'h0002);
        wr(9, 1, 16'h0101); wr(9, 2, 16'h0202); wr(9, 3, 16'h0303);
        wr(9, 4, 16'h00FF);
        ck("R6 no start", pe_start, 0);
        after_abort("R6 bad confirm", 0);

        // R6: confirm code in the upper byte only is also wrong
        wr(9, 0, 16'h00E8); wr(9, 0, 16'h0000); wr(9, 1, 16'h0101);
        wr(9, 4, 16'hD000);
        after_abort("R6 upper-byte confirm", 0);

        finished = 1;
        report();
    end
endmodule